// File: doc/BRIEF.md
# Field Memory Write/Read Sequencer

This block drives the enable lines of two external field memory banks. It runs on the memory clock. A 50 Hz vertical sync is qualified by horizontal blanking and halved into a 25 Hz frame phase.

In one frame phase, bank A takes incoming field data while bank B's read-back path feeds the noise-reduction stage. In the next phase the roles swap. The write/read pattern therefore repeats once every two vertical periods.

The block also delays two serial address control signals by a fixed number of memory-clock cycles, so that they line up with the memory timing.

Top module: `field_bank_sequencer`

## Requirements
- R1: While reset is held, and after reset until the first qualified sync edge, the state is as follows. All four enables are high (inactive) and `frame_start` is low. The frame phase is 0. The two delayed address outputs are 0.
- R2: A qualified sync edge is a clock edge at which `vsync` is sampled high, the previous sample was low, and `hblank` is high. At the first qualified edge after reset, the pattern starts in phase 0. The enables take their new values at that same clock edge.
- R3: A `vsync` rise while `hblank` is low has no effect on any enable or on `frame_start`. The same holds for `vsync` staying high.
- R4: In phase 0, `wr_a_n`=0, `wr_b_n`=1, `rd_a_n`=1 and `rd_b_n`=0. In phase 1, `wr_a_n`=1, `wr_b_n`=0, `rd_a_n`=0 and `rd_b_n`=1.
- R5: Every qualified edge after the first one toggles the phase. The full pattern therefore repeats every two qualified edges.
- R6: `wr_a_n` and `wr_b_n` are never low together. `wr_a_n` always equals `rd_b_n`, and `wr_b_n` always equals `rd_a_n`.
- R7: `frame_start` is high for exactly one cycle after each qualified edge that begins phase 0, including the first one. It is low at every other time.
- R8: The values of `sa_col_in` and `sa_row_in` sampled at one clock edge appear on `sa_col_out` and `sa_row_out` after the fourth clock edge (ADDR_DLY=4). The two bits are carried independently.
- R9: The enables change only at a qualified edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync | input | 1 | 50 Hz vertical sync |
| hblank | input | 1 | Horizontal blanking, high while blanking |
| sa_col_in | input | 1 | Serial column address control in |
| sa_row_in | input | 1 | Serial row address control in |
| wr_a_n | output | 1 | Write enable of bank A, active low |
| wr_b_n | output | 1 | Write enable of bank B, active low |
| rd_a_n | output | 1 | Read-back enable of bank A, active low |
| rd_b_n | output | 1 | Read-back enable of bank B, active low |
| frame_start | output | 1 | One-cycle 25 Hz pattern start pulse |
| sa_col_out | output | 1 | Delayed column address control |
| sa_row_out | output | 1 | Delayed row address control |

## Verification
The enables and `frame_start` settle at the same edge that samples a qualified `vsync` rise. For this reason, each stimulus is applied on a falling edge and its result is read on the following falling edge. The delayed address bits are due four edges after they are sampled. The bench therefore compares them with the table entry three steps earlier, and expects zero for the first three steps after reset. A reset asserted mid-run, followed by an address walk, covers the return to the idle state and the exact delay.

// File: rtl/field_bank_sequencer.sv
module field_bank_sequencer #(
  parameter int ADDR_DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vsync,
  input  logic hblank,
  input  logic sa_col_in,
  input  logic sa_row_in,
  output logic wr_a_n,
  output logic wr_b_n,
  output logic rd_a_n,
  output logic rd_b_n,
  output logic frame_start,
  output logic sa_col_out,
  output logic sa_row_out
);

  logic vs_q, run_q, phase_q;
  logic [1:0] dly_q [ADDR_DLY];

  wire qual      = vsync & ~vs_q & hblank;
  wire nxt_run   = run_q | qual;
  wire nxt_phase = (qual & run_q) ? ~phase_q : phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q        <= 1'b0;
      run_q       <= 1'b0;
      phase_q     <= 1'b0;
      wr_a_n      <= 1'b1;
      wr_b_n      <= 1'b1;
      rd_a_n      <= 1'b1;
      rd_b_n      <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      vs_q        <= vsync;
      run_q       <= nxt_run;
      phase_q     <= nxt_phase;
      wr_a_n      <= ~(nxt_run & ~nxt_phase);
      wr_b_n      <= ~(nxt_run &  nxt_phase);
      rd_a_n      <= ~(nxt_run &  nxt_phase);
      rd_b_n      <= ~(nxt_run & ~nxt_phase);
      frame_start <= qual & ~nxt_phase;
    end
  end

  generate
    for (genvar s = 0; s < ADDR_DLY; s++) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dly_q[s] <= 2'b00;
        else if (s == 0) dly_q[s] <= {sa_col_in, sa_row_in};
        else             dly_q[s] <= dly_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sa_col_out = dly_q[ADDR_DLY-1][1];
  assign sa_row_out = dly_q[ADDR_DLY-1][0];

  a_r6_one_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_a_n && !wr_b_n));
  a_r6_cross_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_a_n == rd_b_n) && (wr_b_n == rd_a_n));
  a_r9_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(vsync) |=> $stable({wr_a_n, wr_b_n, rd_a_n, rd_b_n}));
  a_r7_start_in_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!wr_a_n && !rd_b_n));
  a_r1_idle_until_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> ({wr_a_n, wr_b_n, rd_a_n, rd_b_n} == 4'b1111 && !frame_start));

endmodule

// File: tb/test_field_bank_sequencer.sv
module test_field_bank_sequencer;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vsync = 1'b0, hblank = 1'b0, sa_col_in = 1'b0, sa_row_in = 1'b0;
  logic wr_a_n, wr_b_n, rd_a_n, rd_b_n, frame_start, sa_col_out, sa_row_out;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  field_bank_sequencer #(.ADDR_DLY(4)) i_field_bank_sequencer (
    .clk(clk), .rst_n(rst_n), .vsync(vsync), .hblank(hblank),
    .sa_col_in(sa_col_in), .sa_row_in(sa_row_in),
    .wr_a_n(wr_a_n), .wr_b_n(wr_b_n), .rd_a_n(rd_a_n), .rd_b_n(rd_b_n),
    .frame_start(frame_start), .sa_col_out(sa_col_out), .sa_row_out(sa_row_out));

  // {vsync, hblank, col, row, wr_a_n, wr_b_n, rd_a_n, rd_b_n, frame_start}
  localparam logic [8:0] VEC [20] = '{
    9'b00_10_1111_0, 9'b10_01_1111_0, 9'b11_11_1111_0, 9'b01_00_1111_0,
    9'b11_10_0110_1, 9'b11_01_0110_0, 9'b00_11_0110_0, 9'b10_00_0110_0,
    9'b00_10_0110_0, 9'b11_01_1001_0, 9'b10_11_1001_0, 9'b01_00_1001_0,
    9'b11_10_0110_1, 9'b01_01_0110_0, 9'b11_11_1001_0, 9'b00_00_1001_0,
    9'b01_10_1001_0, 9'b11_01_0110_1, 9'b11_11_0110_0, 9'b00_00_0110_0};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {1'b0, wr_a_n, wr_b_n, rd_a_n, rd_b_n, frame_start, sa_col_out, sa_row_out},
        8'b0_1111_0_00);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      {vsync, hblank, sa_col_in, sa_row_in} = VEC[i][8:5];
      @(negedge clk);
      // R2 R3 R4 R5 R9: enables; R7: frame pulse
      chk($sformatf("R2/R3/R4/R5/R9 enables step %0d", i),
          {4'b0, wr_a_n, wr_b_n, rd_a_n, rd_b_n}, {4'b0, VEC[i][4:1]});
      chk($sformatf("R7 frame_start step %0d", i), {7'b0, frame_start}, {7'b0, VEC[i][0]});
      // R6: write exclusivity and pairing
      chk($sformatf("R6 pairing step %0d", i), {6'b0, wr_a_n ^ rd_b_n, !wr_a_n && !wr_b_n}, 8'b0);
      // R8: four-edge address delay
      chk($sformatf("R8 address step %0d", i), {6'b0, sa_col_out, sa_row_out},
          (i >= 3) ? {6'b0, VEC[i-3][6:5]} : 8'b0);
    end
    // R1: mid-run reset returns to idle
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset", {1'b0, wr_a_n, wr_b_n, rd_a_n, rd_b_n, frame_start, sa_col_out, sa_row_out},
        8'b0_1111_0_00);
    {vsync, hblank, sa_col_in, sa_row_in} = 4'b0000;
    rst_n = 1'b1;
    // R8: a single pulse per bit, observed exactly on the fourth edge
    sa_col_in = 1'b1;
    @(negedge clk);
    sa_col_in = 1'b0; sa_row_in = 1'b1;
    @(negedge clk);
    sa_row_in = 1'b0;
    @(negedge clk);
    chk("R8 col not early", {7'b0, sa_col_out}, 8'b0);
    @(negedge clk);
    chk("R8 col on fourth edge", {6'b0, sa_col_out, sa_row_out}, 8'b10);
    @(negedge clk);
    chk("R8 row on fourth edge", {6'b0, sa_col_out, sa_row_out}, 8'b01);
    @(negedge clk);
    chk("R8 cleared", {6'b0, sa_col_out, sa_row_out}, 8'b00);
    // R1: still idle (no sync edge since reset); R2: first edge gives phase 0
    chk("R1 idle after reset", {4'b0, wr_a_n, wr_b_n, rd_a_n, rd_b_n}, 8'b0000_1111);
    vsync = 1'b1; hblank = 1'b1;
    @(negedge clk);
    chk("R2 first edge phase 0", {3'b0, wr_a_n, wr_b_n, rd_a_n, rd_b_n, frame_start}, 8'b000_0110_1);
    finish_run();
  end

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule